// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer with Single-Shot Pulse-Width Capture

This block is a 16-bit up-counter with three ways of advancing. It can count the active edges of an external input pin, count cycles of an internal tick enable, or time how long that pin stays at a level. When the count steps past all-ones, the counter reloads from a preload register. At the same moment it raises a wake-up pulse and, if enabled, a sticky interrupt flag. The external pin is asynchronous, so it passes through a two-flop synchroniser before any edge or level decision is made.

Software controls the block through a run bit with separate set and clear strobes, a two-bit mode field, an edge-select bit and a preload write strobe. While the run bit is low, a preload write also loads the counter. While it is high, the write only updates the value used at the next reload.

In pulse-width mode a small state machine waits for a trigger transition on the pin. It then counts ticks while the pin holds the level entered on that transition. When the pin returns to its original level, the machine clears the run bit by itself, so exactly one measurement is taken and the count is held until software re-arms the block.

The machine has three states:
- PW_IDLE: the block is not armed in pulse mode.
- PW_ARMED: the block waits for the trigger edge.
- PW_MEASURE: ticks are being counted.

It has four transitions:
- arm: PW_IDLE to PW_ARMED, when the run bit is 1 and the mode is 11.
- trigger: PW_ARMED to PW_MEASURE, on the selected edge.
- finish: PW_MEASURE to PW_IDLE, when the level returns. This clears the run bit.
- abort: any state to PW_IDLE, when the run bit drops or the mode leaves 11.

Top module: `mode_timer16`

## Requirements
- R1: While reset is low, and immediately after it is released, count_o, run_o, irq_o, wake_o and run_autoclr_o are all 0, and the preload value is 0.
- R2: The mode encoding is 00 = off, 01 = event count, 10 = timer, 11 = pulse width. In mode 00 the count never changes except through a preload write made while the run bit is low.
- R3: In event mode with the run bit at 1, the count steps by one per active pin edge: rising when edge_sel_i = 1, falling when edge_sel_i = 0. The step becomes visible at the third rising clock edge after the pin changes.
- R4: In timer mode with the run bit at 1, the count steps by one at every clock edge where tick_i = 1.
- R5: In every mode, a step taken from all-ones loads the preload value instead. wake_o is 1 for exactly the cycle that follows such a step.
- R6: An overflow sets irq_o only when irq_en_i = 1. irq_o stays set until irq_clr_i is 1, and setting wins over clearing. irq_en_i has no effect on wake_o.
- R7: A preload write while the run bit is 0 loads both the preload value and the count. While the run bit is 1 it changes only the preload value, which is then used at the next overflow.
- R8: In pulse-width mode, counting starts only on a trigger transition of the synchronised pin: rising when edge_sel_i = 1, falling when edge_sel_i = 0. A pin already at the active level when the block is armed does not start counting. While measuring, the count steps on every tick.
- R9: In pulse-width mode, when the pin returns to its original level, the hardware clears the run bit and pulses run_autoclr_o for one cycle. The count is held, and later transitions are ignored until run_set_i is asserted again.
- R10: run_set_i sets the run bit and run_clr_i clears it; when both are 1, set wins. In modes 01 and 10 the hardware never clears the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | External asynchronous input |
| tick_i | input | 1 | Internal tick enable |
| mode_i | input | 2 | Mode select (00 off, 01 event, 10 timer, 11 pulse width) |
| edge_sel_i | input | 1 | 1 = rising edge / high level active, 0 = falling / low |
| run_set_i | input | 1 | Software strobe that sets the run bit |
| run_clr_i | input | 1 | Software strobe that clears the run bit |
| preload_wr_i | input | 1 | Preload write strobe |
| preload_i | input | 16 | Preload write data |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Interrupt flag clear strobe |
| count_o | output | 16 | Current count |
| run_o | output | 1 | Run bit |
| irq_o | output | 1 | Sticky interrupt request flag |
| wake_o | output | 1 | One-cycle pulse after each overflow |
| run_autoclr_o | output | 1 | One-cycle pulse when the hardware clears the run bit |

## Verification
The assertions assume that every input except pin_i is synchronous to clk_i and stable around the rising edge. They also assume that strobes such as run_set_i and preload_wr_i mean one action per cycle in which they are high. The bench keeps within this by changing every input on the falling edge and holding strobes for whole cycles. pin_i alone is allowed to change freely, because the synchroniser delay is part of the modelled behaviour. The randomised phase biases preload values toward all-ones so that overflows happen in every mode, including in the middle of a pulse measurement.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        PW_IDLE    = 2'b00,
        PW_ARMED   = 2'b01,
        PW_MEASURE = 2'b10
    } pw_state_e;
endpackage

// File: rtl/mtmr_sync.sv
module mtmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= pin_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= {chain_q[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) last_q <= 1'b0;
        else         last_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = level_o & ~last_q;
    assign fall_o  = ~level_o & last_q;
endmodule

// File: rtl/mtmr_pwfsm.sv
module mtmr_pwfsm
    import mtmr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pulse_mode_i,
    input  logic edge_sel_i,
    input  logic level_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic measure_o,
    output logic done_o
);
    pw_state_e state_q, state_d;
    logic      trig;
    logic      level_ok;

    assign trig     = edge_sel_i ? rise_i : fall_i;
    assign level_ok = (level_i == edge_sel_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= PW_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!pulse_mode_i) begin
            state_d = PW_IDLE;
        end else begin
            unique case (state_q)
                PW_IDLE:    state_d = PW_ARMED;
                PW_ARMED:   if (trig) state_d = PW_MEASURE;
                PW_MEASURE: if (!level_ok) state_d = PW_IDLE;
                default:    state_d = PW_IDLE;
            endcase
        end
    end

    always_comb begin
        measure_o = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            PW_MEASURE: begin
                measure_o = pulse_mode_i & level_ok;
                done_o    = pulse_mode_i & ~level_ok;
            end
            default: begin
                measure_o = 1'b0;
                done_o    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             running_i,
    input  logic             pre_wr_i,
    input  logic [WIDTH-1:0] pre_data_i,
    output logic [WIDTH-1:0] count_o,
    output logic             wrap_o
);
    localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] pre_q;
    logic             direct_load;

    assign direct_load = pre_wr_i & ~running_i;
    assign wrap_o      = step_i & ~direct_load & (cnt_q == CNT_MAX);
    assign count_o     = cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else begin
            if (pre_wr_i) pre_q <= pre_data_i;
            if (direct_load)  cnt_q <= pre_data_i;
            else if (wrap_o)  cnt_q <= pre_q;
            else if (step_i)  cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mode_timer16.sv
module mode_timer16
    import mtmr_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pin_i,
    input  logic             tick_i,
    input  logic [1:0]       mode_i,
    input  logic             edge_sel_i,
    input  logic             run_set_i,
    input  logic             run_clr_i,
    input  logic             preload_wr_i,
    input  logic [WIDTH-1:0] preload_i,
    input  logic             irq_en_i,
    input  logic             irq_clr_i,
    output logic [WIDTH-1:0] count_o,
    output logic             run_o,
    output logic             irq_o,
    output logic             wake_o,
    output logic             run_autoclr_o
);
    mode_e mode;
    logic  level, rise, fall;
    logic  measure, done;
    logic  step, wrap;
    logic  run_q, irq_q, wake_q, ac_q;

    assign mode = mode_e'(mode_i);

    mtmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (pin_i),
        .level_o (level),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    mtmr_pwfsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .pulse_mode_i (run_q && (mode == MODE_PULSE)),
        .edge_sel_i   (edge_sel_i),
        .level_i      (level),
        .rise_i       (rise),
        .fall_i       (fall),
        .measure_o    (measure),
        .done_o       (done)
    );

    always_comb begin
        step = 1'b0;
        unique case (mode)
            MODE_OFF:   step = 1'b0;
            MODE_EVENT: step = run_q & (edge_sel_i ? rise : fall);
            MODE_TIMER: step = run_q & tick_i;
            MODE_PULSE: step = run_q & measure & tick_i;
            default:    step = 1'b0;
        endcase
    end

    mtmr_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (step),
        .running_i  (run_q),
        .pre_wr_i   (preload_wr_i),
        .pre_data_i (preload_i),
        .count_o    (count_o),
        .wrap_o     (wrap)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q  <= 1'b0;
            irq_q  <= 1'b0;
            wake_q <= 1'b0;
            ac_q   <= 1'b0;
        end else begin
            if (run_set_i)              run_q <= 1'b1;
            else if (run_clr_i || done) run_q <= 1'b0;
            if (wrap && irq_en_i)       irq_q <= 1'b1;
            else if (irq_clr_i)         irq_q <= 1'b0;
            wake_q <= wrap;
            ac_q   <= done;
        end
    end

    assign run_o         = run_q;
    assign irq_o         = irq_q;
    assign wake_o        = wake_q;
    assign run_autoclr_o = ac_q;
endmodule

// File: rtl/mode_timer16_chk.sv
module mode_timer16_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       mode_i,
    input logic             run_set_i,
    input logic             run_clr_i,
    input logic             preload_wr_i,
    input logic             irq_en_i,
    input logic [WIDTH-1:0] count_o,
    input logic             run_o,
    input logic             irq_o,
    input logic             wake_o,
    input logic             run_autoclr_o
);
    // R6
    irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(irq_en_i));

    // R5
    wake_from_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> ($past(count_o) == {WIDTH{1'b1}}));

    // R9
    hw_clear_flagged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(run_o) && !$past(run_clr_i)) |-> run_autoclr_o);

    // R9
    autoclr_pulse_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_autoclr_o |-> ($past(mode_i) == 2'b11));

    // R2
    off_mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b00 && !preload_wr_i) |=> $stable(count_o));

    // R3
    single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o != $past(count_o) && !$past(preload_wr_i))
            |-> ((count_o == $past(count_o) + 1'b1) || wake_o));

    // R10
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_set_i |=> run_o);
endmodule

bind mode_timer16 mode_timer16_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/mode_timer16_test.sv
module mode_timer16_test;
    localparam int W = 16;

    logic         clk = 1'b0, rst_n = 1'b0;
    logic         pin = 1'b0, tick = 1'b0, edge_sel = 1'b0;
    logic         run_set = 1'b0, run_clr = 1'b0, pre_wr = 1'b0;
    logic         irq_en = 1'b0, irq_clr = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] pre_in = '0;
    logic [W-1:0] count;
    logic         run, irq, wake, autoclr;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mode_timer16 uut (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .tick_i(tick), .mode_i(mode),
        .edge_sel_i(edge_sel), .run_set_i(run_set), .run_clr_i(run_clr),
        .preload_wr_i(pre_wr), .preload_i(pre_in), .irq_en_i(irq_en),
        .irq_clr_i(irq_clr), .count_o(count), .run_o(run), .irq_o(irq),
        .wake_o(wake), .run_autoclr_o(autoclr)
    );

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    logic [W-1:0] m_cnt = '0, m_pre = '0;
    bit m_run = 0, m_irq = 0, m_wake = 0, m_ac = 0;
    int m_st = 0;
    bit h0 = 0, h1 = 0, h2 = 0;

    always @(posedge clk) begin : model
        bit lv, rs, fl, trig, pm, stp, dn, wrap;
        int nst;
        string tag;
        if (!rst_n) begin
            m_cnt = '0; m_pre = '0; m_run = 0; m_irq = 0; m_wake = 0; m_ac = 0;
            m_st = 0; h0 = 0; h1 = 0; h2 = 0;
        end else begin
            lv = h1; rs = h1 & ~h2; fl = ~h1 & h2;
            trig = edge_sel ? rs : fl;
            pm = m_run && (mode == 2'b11);
            case (mode)
                2'b01:   stp = m_run && trig;
                2'b10:   stp = m_run && tick;
                2'b11:   stp = m_run && (m_st == 2) && (lv == edge_sel) && tick;
                default: stp = 0;
            endcase
            dn = (m_st == 2) && pm && (lv != edge_sel);
            if (!pm) nst = 0;
            else if (m_st == 0) nst = 1;
            else if (m_st == 1) nst = trig ? 2 : 1;
            else nst = dn ? 0 : 2;
            wrap = 0;
            if (pre_wr && !m_run) m_cnt = pre_in;
            else if (stp) begin
                wrap = (m_cnt == 16'hFFFF);
                m_cnt = wrap ? m_pre : m_cnt + 16'd1;
            end
            if (pre_wr) m_pre = pre_in;
            if (wrap && irq_en) m_irq = 1;
            else if (irq_clr) m_irq = 0;
            m_wake = wrap;
            m_ac = dn;
            if (run_set) m_run = 1;
            else if (run_clr || dn) m_run = 0;
            m_st = nst;
            h2 = h1; h1 = h0; h0 = pin;
        end
        #1;
        case (mode)
            2'b00:   tag = "R2 count";
            2'b01:   tag = "R3 count";
            2'b10:   tag = "R4 count";
            default: tag = "R8 count";
        endcase
        chk(count, m_cnt, tag);
        chk(W'(run), W'(m_run), "R10 run");
        chk(W'(irq), W'(m_irq), "R6 irq");
        chk(W'(wake), W'(m_wake), "R5 wake");
        chk(W'(autoclr), W'(m_ac), "R9 autoclr");
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pulse();
        run_set = 1; cyc(1); run_set = 0;
    endtask

    task automatic clr_pulse();
        run_clr = 1; cyc(1); run_clr = 0;
    endtask

    task automatic wr_pre(input logic [W-1:0] v);
        pre_in = v; pre_wr = 1; cyc(1); pre_wr = 0;
    endtask

    task automatic pin_pulse(input int hi, input int lo);
        pin = ~pin; cyc(hi); pin = ~pin; cyc(lo);
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        // R1 reset state
        chk(count, 16'h0000, "R1 count"); chk(W'(run), 0, "R1 run");
        chk(W'(irq), 0, "R1 irq"); chk(W'(wake), 0, "R1 wake"); chk(W'(autoclr), 0, "R1 autoclr");
        cyc(1);
        // R7 load while stopped
        wr_pre(16'hFFF0);
        chk(count, 16'hFFF0, "R7 stopped load");
        // R2 off mode
        set_pulse(); mode = 2'b00; tick = 1; cyc(10);
        chk(count, 16'hFFF0, "R2 off mode frozen"); chk(W'(run), 1, "R10 run set");
        // R4 timer with overflow
        irq_en = 1; mode = 2'b10; cyc(16);
        chk(count, 16'hFFF0, "R5 reload"); chk(W'(wake), 1, "R5 wake");
        chk(W'(irq), 1, "R6 irq set");
        // R7 write while running
        wr_pre(16'h1234);
        chk(count, 16'hFFF1, "R7 running write keeps count");
        irq_clr = 1; irq_en = 0; cyc(1); irq_clr = 0;
        chk(W'(irq), 0, "R6 irq cleared");
        cyc(14);
        chk(count, 16'h1234, "R7 new preload used"); chk(W'(wake), 1, "R6 wake without enable");
        chk(W'(irq), 0, "R6 masked irq");
        // R3 event mode
        tick = 0; clr_pulse(); mode = 2'b01; edge_sel = 1; pin = 0;
        wr_pre(16'hFFFE);
        chk(count, 16'hFFFE, "R7 stopped load");
        set_pulse(); wr_pre(16'h0005);
        repeat (3) pin_pulse(3, 3);
        cyc(2);
        chk(count, 16'h0006, "R3 rising edges");
        edge_sel = 0;
        repeat (2) pin_pulse(3, 3);
        cyc(2);
        chk(count, 16'h0008, "R3 falling edges"); chk(W'(run), 1, "R10 no hw clear");
        // R8 pulse width, high level
        clr_pulse(); mode = 2'b11; edge_sel = 1; pin = 1; wr_pre(16'h0000);
        cyc(4); set_pulse(); tick = 1; cyc(6);
        chk(count, 16'h0000, "R8 no start on level");
        pin = 0; cyc(4); pin = 1; cyc(10); pin = 0; cyc(6);
        chk(count, 16'h0009, "R8 high width"); chk(W'(run), 0, "R9 run cleared");
        pin_pulse(5, 5);
        chk(count, 16'h0009, "R9 further edges ignored"); chk(W'(run), 0, "R9 stays clear");
        // R8 low level with overflow
        irq_en = 1; edge_sel = 0; pin = 1; wr_pre(16'hFFFC);
        cyc(4); set_pulse(); cyc(3);
        pin = 0; cyc(8); pin = 1; cyc(6);
        chk(count, 16'hFFFF, "R8 low width with reload"); chk(W'(irq), 1, "R5 pulse-mode overflow");
        chk(W'(run), 0, "R9 run cleared");
        // R10 set wins
        run_set = 1; run_clr = 1; cyc(1); run_set = 0; run_clr = 0;
        chk(W'(run), 1, "R10 set wins");
        // randomised phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 63) == 0) mode = 2'($urandom);
            if ($urandom_range(0, 5) == 0) pin = ~pin;
            if ($urandom_range(0, 49) == 0) edge_sel = ~edge_sel;
            if ($urandom_range(0, 31) == 0) irq_en = ~irq_en;
            tick = 1'($urandom);
            run_set = ($urandom_range(0, 9) == 0);
            run_clr = ($urandom_range(0, 19) == 0);
            irq_clr = ($urandom_range(0, 7) == 0);
            pre_wr = ($urandom_range(0, 39) == 0);
            pre_in = 16'hFFC0 | 16'($urandom_range(0, 63));
            cyc(1);
        end
        run_set = 0; run_clr = 0; irq_clr = 0; pre_wr = 0;
        cyc(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule